// File: doc/BRIEF.md
# Instruction store loader with parity

This block is the host-facing programming port and fetch port of a small engine's instruction memory. The host first writes an address/control word that turns on loading mode and sets the starting location. It then supplies each 40-bit instruction in two 32-bit register writes: a low word and a high word. Only the high-word write commits the instruction to the store, and that same write advances the location counter by one.

Every stored entry carries two even-parity bits next to the instruction. The host computes these bits and supplies them in the high word. The store does not generate them. When the counter moves past the last entry it wraps to zero. Reading the address register then returns only the mode bit, so loader software can tell that the store is full. This is how it knows to stop padding the end of a program with no-operation words.

The engine side reads instructions through a one-cycle fetch port. When checking is enabled in the control register, a parity mismatch on a fetched word raises a one-cycle error pulse. The pulse also sets a sticky error flag, which the host clears by writing the control register.

Top module: `istore_loader`

## Requirements
- R1: After a synchronous reset, loading mode is off, the location counter is 0, the control word is 0, the error flag is low and no fetch result is valid.
- R2: A write to offset 0x000 loads loading mode from data bit 31 and the location counter from the low log2(DEPTH) data bits. A read of offset 0x000 returns the mode in bit 31 and the counter in the low bits, with zeros elsewhere.
- R3: A write to offset 0x004 only holds the low instruction word. Without a following high-word write, neither the store nor the counter changes.
- R4: In loading mode, a write to offset 0x008 stores an entry at the current location and advances the counter by one. The entry is made of instruction bits 31:0 from the held low word, instruction bits 39:32 from data bits 7:0, entry bit 40 from data bit 8 and entry bit 41 from data bit 9.
- R5: A commit at the last location (DEPTH-1) wraps the counter to 0, so the address read returns 0x80000000 while loading mode is on.
- R6: Outside loading mode, a write to offset 0x008 neither changes the store nor moves the counter.
- R7: A fetch request on a clock edge presents that location's 40-bit instruction with a valid strobe during the following cycle. The strobe is low in a cycle after no request.
- R8: Bit 40 of an entry is even parity over instruction bits 19:0, and bit 41 is even parity over bits 39:20. The fetch error pulse is high in the valid cycle when either bit mismatches and bit 28 of the control register (offset 0x018) is set. It stays low while that bit is clear.
- R9: A fetch error pulse sets a sticky error flag on the next edge. The flag stays set through later clean fetches and is cleared by any write to the control register at offset 0x018.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Host register write strobe |
| csr_addr | input | 12 | Host register byte offset |
| csr_wdata | input | 32 | Host write data |
| csr_rdata | output | 32 | Host read data for the offset on csr_addr (combinational) |
| fetch_en | input | 1 | Fetch request |
| fetch_addr | input | log2(DEPTH) | Fetch location |
| fetch_valid | output | 1 | Fetch result valid |
| fetch_insn | output | 40 | Fetched instruction |
| fetch_perr | output | 1 | Parity mismatch on the current fetch result |
| err_flag | output | 1 | Sticky parity error flag |

## Verification
The counter properties assume the host issues one register write per cycle. A commit on the same edge as an address-register write is not expected, because the address write takes precedence. The bench keeps one write per task call and never overlaps fetch requests with host writes to the same location. Parity errors are produced only on purpose, by supplying flipped parity bits through the high-word write. Every location fetched has first been written.

// File: rtl/istl_pkg.sv
package istl_pkg;

    localparam int INSN_W   = 40;
    localparam int CSR_AW   = 12;
    localparam int CHK_BIT  = 28;
    localparam int MODE_BIT = 31;

    localparam logic [CSR_AW-1:0] OFS_ADDR = 12'h000;
    localparam logic [CSR_AW-1:0] OFS_LO   = 12'h004;
    localparam logic [CSR_AW-1:0] OFS_HI   = 12'h008;
    localparam logic [CSR_AW-1:0] OFS_CTL  = 12'h018;

    localparam logic [INSN_W-1:0] NOP_INSN = 40'hF0000C0300;

    typedef struct packed {
        logic [1:0]        par;   // [1] covers 39:20, [0] covers 19:0
        logic [INSN_W-1:0] insn;
    } sword_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ADDR,
        SEL_LO,
        SEL_HI,
        SEL_CTL
    } csr_sel_e;

    function automatic csr_sel_e csr_decode(logic [CSR_AW-1:0] ofs);
        case (ofs)
            OFS_ADDR: return SEL_ADDR;
            OFS_LO:   return SEL_LO;
            OFS_HI:   return SEL_HI;
            OFS_CTL:  return SEL_CTL;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [1:0] even_par(logic [INSN_W-1:0] v);
        return {^v[39:20], ^v[19:0]};
    endfunction

endpackage

// File: rtl/istl_csr.sv
module istl_csr
    import istl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CSR_AW-1:0] ofs,
    input  logic [31:0]       wdata,
    input  logic              perr,
    output logic [31:0]       rdata,
    output logic              prog,
    output logic [AW-1:0]     cur_addr,
    output logic              commit,
    output sword_t            commit_word,
    output logic              chk_en,
    output logic              err_flag
);

    csr_sel_e    sel;
    logic [31:0] lo_q;
    logic [31:0] ctl_q;
    logic        prog_q;
    logic [AW-1:0] addr_q;
    logic        err_q;

    assign sel    = csr_decode(ofs);
    assign commit = wr && (sel == SEL_HI) && prog_q;

    assign commit_word.insn = {wdata[7:0], lo_q};
    assign commit_word.par  = wdata[9:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= 1'b0;
            addr_q <= '0;
            lo_q   <= '0;
            ctl_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr && sel == SEL_ADDR) begin
                prog_q <= wdata[MODE_BIT];
                addr_q <= wdata[AW-1:0];
            end else if (commit) begin
                addr_q <= addr_q + 1'b1;
            end
            if (wr && sel == SEL_LO)
                lo_q <= wdata;
            if (wr && sel == SEL_CTL)
                ctl_q <= wdata;
            if (perr)
                err_q <= 1'b1;
            else if (wr && sel == SEL_CTL)
                err_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_ADDR: begin
                rdata[MODE_BIT] = prog_q;
                rdata[AW-1:0]   = addr_q;
            end
            SEL_LO:  rdata = lo_q;
            SEL_CTL: rdata = ctl_q;
            default: rdata = '0;
        endcase
    end

    assign prog     = prog_q;
    assign cur_addr = addr_q;
    assign chk_en   = ctl_q[CHK_BIT];
    assign err_flag = err_q;

endmodule

// File: rtl/istl_store.sv
module istl_store
    import istl_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  sword_t            wword,
    input  logic              fetch_en,
    input  logic [AW-1:0]     fetch_addr,
    input  logic              chk_en,
    output logic              fetch_valid,
    output logic [INSN_W-1:0] fetch_insn,
    output logic              fetch_perr
);

    sword_t mem [DEPTH];
    sword_t rd_q;
    logic   valid_q;

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wword;
        if (fetch_en)
            rd_q <= mem[fetch_addr];
    end

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else
            valid_q <= fetch_en;
    end

    assign fetch_valid = valid_q;
    assign fetch_insn  = rd_q.insn;
    assign fetch_perr  = valid_q && chk_en && (even_par(rd_q.insn) != rd_q.par);

endmodule

// File: rtl/istore_loader.sv
module istore_loader
    import istl_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              fetch_en,
    input  logic [AW-1:0]     fetch_addr,
    output logic              fetch_valid,
    output logic [INSN_W-1:0] fetch_insn,
    output logic              fetch_perr,
    output logic              err_flag
);

    logic          prog;
    logic [AW-1:0] cur_addr;
    logic          commit;
    sword_t        commit_word;
    logic          chk_en;

    istl_csr #(.AW(AW)) u_csr (
        .clk         (clk),
        .rst         (rst),
        .wr          (csr_wr),
        .ofs         (csr_addr),
        .wdata       (csr_wdata),
        .perr        (fetch_perr),
        .rdata       (csr_rdata),
        .prog        (prog),
        .cur_addr    (cur_addr),
        .commit      (commit),
        .commit_word (commit_word),
        .chk_en      (chk_en),
        .err_flag    (err_flag)
    );

    istl_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk         (clk),
        .rst         (rst),
        .we          (commit),
        .waddr       (cur_addr),
        .wword       (commit_word),
        .fetch_en    (fetch_en),
        .fetch_addr  (fetch_addr),
        .chk_en      (chk_en),
        .fetch_valid (fetch_valid),
        .fetch_insn  (fetch_insn),
        .fetch_perr  (fetch_perr)
    );

endmodule

// File: rtl/istl_chk.sv
module istl_chk
    import istl_pkg::*;
#(
    parameter int AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              csr_wr,
    input logic [CSR_AW-1:0] csr_addr,
    input logic [31:0]       csr_wdata,
    input logic              prog,
    input logic [AW-1:0]     cur_addr,
    input logic              fetch_en,
    input logic              fetch_valid,
    input logic              fetch_perr,
    input logic              chk_en,
    input logic              err_flag
);

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_addr == OFS_ADDR) |=> (prog == $past(csr_wdata[MODE_BIT]))); // R2

    AST_LO_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_addr == OFS_LO) |=> $stable(cur_addr)); // R3

    AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_addr == OFS_HI && prog) |=> (cur_addr == AW'($past(cur_addr) + 1'b1))); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_addr == OFS_HI && prog && cur_addr == {AW{1'b1}}) |=> (cur_addr == '0)); // R5

    AST_IDLE_HI_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_addr == OFS_HI && !prog) |=> $stable(cur_addr)); // R6

    AST_FETCH_VALID: assert property (@(posedge clk) disable iff (rst)
        fetch_en |=> fetch_valid); // R7

    AST_FETCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        !fetch_en |=> !fetch_valid); // R7

    AST_PERR_GATED: assert property (@(posedge clk) disable iff (rst)
        fetch_perr |-> (chk_en && fetch_valid)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        fetch_perr |=> err_flag); // R9

endmodule

bind istore_loader istl_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_istore_loader.sv
`timescale 1ns/1ps
module tb_istore_loader;

    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst;
    logic          csr_wr;
    logic [11:0]   csr_addr;
    logic [31:0]   csr_wdata;
    logic [31:0]   csr_rdata;
    logic          fetch_en;
    logic [AW-1:0] fetch_addr;
    logic          fetch_valid;
    logic [39:0]   fetch_insn;
    logic          fetch_perr;
    logic          err_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [39:0] TB_NOP = 40'hF0000C0300;
    localparam logic [39:0] VEC [8] = '{
        40'h0123456789, 40'hFFFFFFFFFF, 40'h0000000000, 40'hA5A5A5A5A5,
        40'h8000000001, 40'h00000FFFFF, 40'hFFFFF00000, 40'h5A3C96E10F
    };

    always #2.5 clk = ~clk;

    istore_loader #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fetch_en(fetch_en),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_insn(fetch_insn),
        .fetch_perr(fetch_perr), .err_flag(err_flag)
    );

    function automatic logic [1:0] tb_par(logic [39:0] v);
        return {^v[39:20], ^v[19:0]};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic put_insn(logic [39:0] v, logic [1:0] par);
        reg_wr(12'h004, v[31:0]);
        reg_wr(12'h008, {22'b0, par, v[39:32]});
    endtask

    // leaves the bench at the negedge inside the valid cycle
    task automatic do_fetch(logic [AW-1:0] a);
        @(negedge clk);
        fetch_en = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; csr_wr = 1'b0; csr_addr = '0; csr_wdata = '0;
        fetch_en = 1'b0; fetch_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_rd(12'h000, rd); check("R1 addr reg", rd, 32'h0);
        reg_rd(12'h018, rd); check("R1 ctl reg", rd, 32'h0);
        check("R1 err_flag", err_flag, 0);
        check("R1 fetch_valid", fetch_valid, 0);

        // R2 enter loading mode at 0
        reg_wr(12'h000, 32'h8000_0000);
        reg_rd(12'h000, rd); check("R2 mode on", rd, 32'h8000_0000);

        // R4 table-driven load with correct parity
        for (int i = 0; i < 8; i++) put_insn(VEC[i], tb_par(VEC[i]));
        reg_rd(12'h000, rd); check("R4 counter after 8", rd, 32'h8000_0008);

        reg_wr(12'h018, 32'h1000_0000);
        for (int i = 0; i < 8; i++) begin
            do_fetch(AW'(i));
            check("R7 valid", fetch_valid, 1);
            check("R7 insn", fetch_insn, VEC[i]);
            check("R8 clean parity", fetch_perr, 0);
        end
        @(negedge clk);
        check("R7 valid drops", fetch_valid, 0);

        // R2 load an address mid-store
        reg_wr(12'h000, 32'h8000_0003);
        reg_rd(12'h000, rd); check("R2 addr load", rd, 32'h8000_0003);
        // R3 lone low word
        reg_wr(12'h004, 32'hDEAD_BEEF);
        reg_rd(12'h000, rd); check("R3 counter unmoved", rd, 32'h8000_0003);
        reg_rd(12'h004, rd); check("R3 low held", rd, 32'hDEAD_BEEF);
        do_fetch(3);
        check("R3 store unchanged", fetch_insn, VEC[3]);

        // R6 writes outside loading mode
        reg_wr(12'h000, 32'h0000_0000);
        reg_rd(12'h000, rd); check("R2 mode off", rd, 32'h0);
        put_insn(40'h1122334455, 2'b00);
        reg_rd(12'h000, rd); check("R6 counter unmoved", rd, 32'h0);
        do_fetch(0);
        check("R6 store unchanged", fetch_insn, VEC[0]);

        // R8 bad bit40 at location 5, R9 sticky
        reg_wr(12'h000, 32'h8000_0005);
        put_insn(VEC[5], tb_par(VEC[5]) ^ 2'b01);
        do_fetch(5);
        check("R8 bit40 mismatch", fetch_perr, 1);
        @(negedge clk);
        check("R9 flag set", err_flag, 1);
        do_fetch(0);
        check("R8 clean after bad", fetch_perr, 0);
        @(negedge clk);
        check("R9 flag sticky", err_flag, 1);
        reg_wr(12'h018, 32'h0000_0000);
        check("R9 flag cleared", err_flag, 0);
        do_fetch(5);
        check("R8 disabled no pulse", fetch_perr, 0);
        @(negedge clk);
        check("R9 no set when disabled", err_flag, 0);

        // R8 bad bit41 at location 6
        reg_wr(12'h018, 32'h1000_0000);
        reg_wr(12'h000, 32'h8000_0006);
        put_insn(VEC[6], tb_par(VEC[6]) ^ 2'b10);
        do_fetch(6);
        check("R8 bit41 mismatch", fetch_perr, 1);
        check("R4 insn with bad par", fetch_insn, VEC[6]);
        reg_wr(12'h018, 32'h1000_0000);

        // R5 wrap via pad loop
        reg_wr(12'h000, 32'h8000_0000 | (DEPTH - 2));
        for (int k = 0; k < 4; k++) begin
            reg_rd(12'h000, rd);
            if (rd == 32'h8000_0000) break;
            put_insn(TB_NOP, tb_par(TB_NOP));
        end
        reg_rd(12'h000, rd); check("R5 wrapped", rd, 32'h8000_0000);
        do_fetch(AW'(DEPTH - 1));
        check("R5 last entry", fetch_insn, TB_NOP);
        check("R8 nop parity", fetch_perr, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule